// File: doc/BRIEF.md
# Display Control Port Command Decoder

This block sits behind the control port of a display and raster processor. Each 32-bit write carries an opcode in its top byte and a 24-bit argument below it. The block turns those writes into changes of a 32-bit status word and into one-cycle pulses for a soft reset and for flushing the command FIFO. It also fills a readback latch when software asks for rendering state such as the drawing area or the drawing offset. The values of that state come in on input ports.

The block also drives the DMA request line. Readiness flags are derived from the blitter state, the command FIFO level and a configurable level threshold. A two-bit direction field then selects which flag, if any, drives the request. The readiness flags and the request are registered, so they follow their inputs and the direction field one clock later. The pixel engine, the FIFO storage and the blitter itself live outside this block.

Top module: `dispctl_top`

## Requirements
- R1: The opcode is `ctl_data[31:24]` and the argument is `ctl_data[23:0]`. After reset, with the blitter idle (code 0), `cmd_busy` low and the FIFO level below the threshold, `status` reads 0x14802000, `rd_latch` reads 0 and `dma_req` is low.
- R2: Opcode 0x00 reloads every stored status field from the value 0x14802000. Under the R1 input conditions, `status` then reads 0x14802000. `soft_rst_p` is high for exactly the one cycle after the write edge, and `rd_latch` is unchanged.
- R3: Opcode 0x01 raises `fifo_clr_p` for exactly one cycle after the write edge and leaves `status` unchanged.
- R4: A pulse on `irq_raise` sets status bit 24, and opcode 0x02 clears it. Opcode 0x03 copies argument bit 0 into status bit 23 (display off).
- R5: The readiness bits are registered one cycle after their inputs. Bit 26 (idle) is 1 only when the blitter code is 0 and `cmd_busy` is low. Bit 27 (ready to send) is 1 only when the blitter code is 2 (reading). Bit 28 (ready to receive) is 1 when the blitter code is not 2 and `fifo_level < fifo_limit`. Code 1 means writing.
- R6: Opcode 0x04 stores argument bits 1:0 as the direction in status bits 30:29. One cycle after the direction or the readiness changes, `dma_req` and status bit 25 follow the selected source: 0 gives 0, 1 and 2 give bit 28, and 3 gives bit 27.
- R7: Opcode 0x08 changes only the status bits in mask 0x007F4000. Argument bits 1:0 go to 18:17, bit 2 to 19, bit 3 to 20, bit 4 to 21, bit 5 to 22, bit 6 to 16 and bit 7 to 14.
- R8: Opcodes 0x10 to 0x1F are queries selected by `ctl_data[2:0]`. Item 2 loads `tex_win`. Item 3 loads `{top, left}` as two 10-bit fields, with left in bits 9:0. Item 4 loads `{bottom, right}` in the same layout. Item 5 loads `{ofs_y, ofs_x}` as two 11-bit fields, with x in bits 10:0. Items 0, 1, 6 and 7 leave `rd_latch` unchanged.
- R9: Opcode 0x09 stores argument bit 0 as a permission flag. A strobe on `tdis_we` then writes `tdis_val` into status bit 15 when the flag is set, and writes 0 when it is clear.
- R10: Opcodes 0x05 to 0x07, 0x0A to 0x0F and 0x20 to 0xFF change neither `status` nor `rd_latch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control port write strobe |
| ctl_data | input | 32 | Control word: opcode and argument |
| irq_raise | input | 1 | Sets the interrupt-request status bit |
| tdis_we | input | 1 | Draw-mode write strobe for the texture-disable bit |
| tdis_val | input | 1 | Requested texture-disable value |
| fifo_level | input | LVL_W | Current command FIFO occupancy |
| fifo_limit | input | LVL_W | Threshold below which the block can accept more data |
| blit_state | input | 2 | 0 idle, 1 writing, 2 reading |
| cmd_busy | input | 1 | Command cycles still outstanding |
| tex_win | input | TW_W | Texture window value |
| area_left | input | AREA_W | Drawing area left |
| area_top | input | AREA_W | Drawing area top |
| area_right | input | AREA_W | Drawing area right |
| area_bottom | input | AREA_W | Drawing area bottom |
| ofs_x | input | OFS_W | Drawing offset x |
| ofs_y | input | OFS_W | Drawing offset y |
| status | output | 32 | Status word |
| dma_req | output | 1 | Registered DMA request |
| soft_rst_p | output | 1 | One-cycle soft reset pulse |
| fifo_clr_p | output | 1 | One-cycle FIFO clear pulse |
| rd_latch | output | 32 | Query readback latch |

## Verification
The bench sweeps every direction against all three blitter states. It uses FIFO levels one below the threshold and exactly at it, so a wrong comparison shows up as a request that stays high at the threshold. A design that let the reading state assert ready-to-receive would raise the request for directions 1 and 2 during a readback. The display-mode write is driven with all ones and then all zeros, which exposes a merge that touches bits outside the mask or misroutes an argument bit. The query items that must leave the latch alone are issued right after a load, and the undefined opcodes are also sent, so a design that clears the latch or decodes an opcode too loosely gives a changed value.

// File: rtl/dispctl_pkg.sv
// Shared constants for the display control port decoder.
// Assumes a 32-bit status word with fixed bit positions used by software.
package dispctl_pkg;
    localparam logic [1:0] BLT_IDLE  = 2'd0;
    localparam logic [1:0] BLT_WRITE = 2'd1;
    localparam logic [1:0] BLT_READ  = 2'd2;

    typedef enum logic [1:0] {
        DIR_OFF     = 2'd0,
        DIR_FIFO    = 2'd1,
        DIR_CPU2CMD = 2'd2,
        DIR_RB2CPU  = 2'd3
    } dma_dir_e;

    localparam logic [31:0] STAT_RESET = 32'h1480_2000;
    localparam logic [31:0] MODE_MASK  = 32'h007F_4000;
    localparam logic [31:0] LIVE_MASK  = 32'h1E00_0000;

    localparam int B_TEXDIS  = 15;
    localparam int B_DISPOFF = 23;
    localparam int B_IRQ     = 24;
    localparam int B_DREQ    = 25;
    localparam int B_IDLE    = 26;
    localparam int B_RTS     = 27;
    localparam int B_RTR     = 28;
    localparam int B_DIR     = 29;

    localparam logic [7:0] OP_SOFTRST = 8'h00;
    localparam logic [7:0] OP_FLUSH   = 8'h01;
    localparam logic [7:0] OP_IRQACK  = 8'h02;
    localparam logic [7:0] OP_DISP    = 8'h03;
    localparam logic [7:0] OP_DMADIR  = 8'h04;
    localparam logic [7:0] OP_MODE    = 8'h08;
    localparam logic [7:0] OP_TDALLOW = 8'h09;
endpackage

// File: rtl/dispctl_ready.sv
// Readiness flags and the direction-selected DMA request.
// Assumes blitter code 3 never occurs; if it does it acts like writing.
// All outputs are registered, one cycle behind their inputs.
module dispctl_ready
    import dispctl_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       blit_state,
    input  logic             cmd_busy,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] fifo_limit,
    input  logic [1:0]       dma_dir,
    output logic             idle_q,
    output logic             rts_q,
    output logic             rtr_q,
    output logic             dreq_q
);
    logic idle_d, rts_d, rtr_d, dreq_d;

    // Derive readiness from the blitter state and the FIFO level, then select the request source.
    always_comb begin
        rts_d  = (blit_state == BLT_READ);
        rtr_d  = (blit_state != BLT_READ) && (fifo_level < fifo_limit);
        idle_d = (blit_state == BLT_IDLE) && !cmd_busy;
        case (dma_dir_e'(dma_dir))
            DIR_FIFO, DIR_CPU2CMD: dreq_d = rtr_d;
            DIR_RB2CPU:            dreq_d = rts_d;
            default:               dreq_d = 1'b0;
        endcase
    end

    // Register the flags; the reset values match the idle reset state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= 1'b1;
            rtr_q  <= 1'b1;
            rts_q  <= 1'b0;
            dreq_q <= 1'b0;
        end else begin
            idle_q <= idle_d;
            rtr_q  <= rtr_d;
            rts_q  <= rts_d;
            dreq_q <= dreq_d;
        end
    end

    a_r5_send_only_read: assert property (@(posedge clk) disable iff (!rst_n)
        (blit_state == BLT_READ) |=> (rts_q && !rtr_q));
    a_r5_no_send_else: assert property (@(posedge clk) disable iff (!rst_n)
        (blit_state != BLT_READ) |=> !rts_q);
    a_r6_off_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_dir == 2'd0) |=> !dreq_q);
    a_r6_req_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        dreq_q |-> (rts_q || rtr_q));
endmodule

// File: rtl/dispctl_info.sv
// Query readback latch: loads packed rendering state on info opcodes.
// Assumes the field widths fit in 32 bits when packed in pairs.
module dispctl_info #(
    parameter int TW_W   = 20,
    parameter int AREA_W = 10,
    parameter int OFS_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [31:0]       ctl_data,
    input  logic [TW_W-1:0]   tex_win,
    input  logic [AREA_W-1:0] area_left,
    input  logic [AREA_W-1:0] area_top,
    input  logic [AREA_W-1:0] area_right,
    input  logic [AREA_W-1:0] area_bottom,
    input  logic [OFS_W-1:0]  ofs_x,
    input  logic [OFS_W-1:0]  ofs_y,
    output logic [31:0]       rd_q
);
    localparam int PAIR_A = 2 * AREA_W;
    localparam int PAIR_O = 2 * OFS_W;

    logic        q_hit;
    logic [2:0]  item;
    logic [31:0] rd_d;
    logic        unused_bits;

    assign q_hit       = ctl_we && (ctl_data[31:28] == 4'h1);
    assign item        = ctl_data[2:0];
    assign unused_bits = ^ctl_data[27:3];

    // Select the packed value for the requested item, or hold.
    always_comb begin
        rd_d = rd_q;
        if (q_hit) begin
            case (item)
                3'd2: rd_d = 32'(tex_win);
                3'd3: rd_d = 32'({area_top, area_left});
                3'd4: rd_d = 32'({area_bottom, area_right});
                3'd5: rd_d = 32'({ofs_y, ofs_x});
                default: rd_d = rd_q;
            endcase
        end
    end

    // Hold the readback value between queries.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    a_r8_keep_items: assert property (@(posedge clk) disable iff (!rst_n)
        (q_hit && (item inside {3'd0, 3'd1, 3'd6, 3'd7})) |=> $stable(rd_q));
    a_r10_nonquery_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !q_hit |=> $stable(rd_q));
    a_r8_area_width: assert property (@(posedge clk) disable iff (!rst_n)
        (q_hit && item == 3'd3) |=> (rd_q[31:PAIR_A] == '0));
    a_r8_ofs_width: assert property (@(posedge clk) disable iff (!rst_n)
        (q_hit && item == 3'd5) |=> (rd_q[31:PAIR_O] == '0));
endmodule

// File: rtl/dispctl_status.sv
// Stored status fields and opcode decode with per-opcode side effects.
// Assumes the live bits 28:25 are supplied by the readiness stage.
module dispctl_status
    import dispctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic [31:0] ctl_data,
    input  logic        irq_raise,
    input  logic        tdis_we,
    input  logic        tdis_val,
    input  logic        idle_q,
    input  logic        rts_q,
    input  logic        rtr_q,
    input  logic        dreq_q,
    output logic [31:0] status,
    output logic [1:0]  dma_dir,
    output logic        soft_rst_p,
    output logic        fifo_clr_p
);
    logic [31:0] st_q, st_d, mode_bits;
    logic        allow_q, allow_d;
    logic [7:0]  op;
    logic [23:0] prm;
    logic        unused_prm;

    assign op         = ctl_data[31:24];
    assign prm        = ctl_data[23:0];
    assign unused_prm = ^prm[23:8];

    // Scatter the display-mode argument onto its status positions.
    always_comb begin
        mode_bits        = '0;
        mode_bits[18:17] = prm[1:0];
        mode_bits[19]    = prm[2];
        mode_bits[20]    = prm[3];
        mode_bits[21]    = prm[4];
        mode_bits[22]    = prm[5];
        mode_bits[16]    = prm[6];
        mode_bits[14]    = prm[7];
    end

    // Apply side-band updates, then the control write; a write wins on conflict.
    always_comb begin
        st_d    = st_q;
        allow_d = allow_q;
        if (irq_raise) st_d[B_IRQ]    = 1'b1;
        if (tdis_we)   st_d[B_TEXDIS] = allow_q & tdis_val;
        if (ctl_we) begin
            case (op)
                OP_SOFTRST: st_d = STAT_RESET & ~LIVE_MASK;
                OP_IRQACK:  st_d[B_IRQ] = 1'b0;
                OP_DISP:    st_d[B_DISPOFF] = prm[0];
                OP_DMADIR:  st_d[B_DIR+1:B_DIR] = prm[1:0];
                OP_MODE:    st_d = (st_d & ~MODE_MASK) | mode_bits;
                OP_TDALLOW: allow_d = prm[0];
                default:    ;
            endcase
        end
    end

    // Stored fields, permission flag and the two command pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= STAT_RESET & ~LIVE_MASK;
            allow_q    <= 1'b0;
            soft_rst_p <= 1'b0;
            fifo_clr_p <= 1'b0;
        end else begin
            st_q       <= st_d;
            allow_q    <= allow_d;
            soft_rst_p <= ctl_we && (op == OP_SOFTRST);
            fifo_clr_p <= ctl_we && (op == OP_FLUSH);
        end
    end

    // Merge the live readiness bits into the visible word.
    always_comb begin
        status         = st_q & ~LIVE_MASK;
        status[B_DREQ] = dreq_q;
        status[B_IDLE] = idle_q;
        status[B_RTS]  = rts_q;
        status[B_RTR]  = rtr_q;
    end
    assign dma_dir = st_q[B_DIR+1:B_DIR];

    a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && op == OP_SOFTRST) |=> ((st_q & ~LIVE_MASK) == (STAT_RESET & ~LIVE_MASK)));
    a_r7_mask_only: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && op == OP_MODE && !irq_raise && !tdis_we)
        |=> ((st_q & ~MODE_MASK) == $past(st_q & ~MODE_MASK)));
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && op == OP_IRQACK) |=> !st_q[B_IRQ]);
    a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (tdis_we && !allow_q && !(ctl_we && op == OP_SOFTRST)) |=> !st_q[B_TEXDIS]);
    a_r10_unknown_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && (op inside {[8'h05:8'h07], [8'h0A:8'h0F], [8'h20:8'hFF]})
         && !irq_raise && !tdis_we) |=> $stable(st_q));
    a_r3_flush_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && op == OP_FLUSH && !irq_raise && !tdis_we) |=> $stable(st_q));
endmodule

// File: rtl/dispctl_top.sv
// Control port decoder top: status word, DMA request, pulses and readback.
// Assumes single-cycle write strobes and synchronous inputs.
module dispctl_top #(
    parameter int LVL_W  = 6,
    parameter int TW_W   = 20,
    parameter int AREA_W = 10,
    parameter int OFS_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [31:0]       ctl_data,
    input  logic              irq_raise,
    input  logic              tdis_we,
    input  logic              tdis_val,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [LVL_W-1:0]  fifo_limit,
    input  logic [1:0]        blit_state,
    input  logic              cmd_busy,
    input  logic [TW_W-1:0]   tex_win,
    input  logic [AREA_W-1:0] area_left,
    input  logic [AREA_W-1:0] area_top,
    input  logic [AREA_W-1:0] area_right,
    input  logic [AREA_W-1:0] area_bottom,
    input  logic [OFS_W-1:0]  ofs_x,
    input  logic [OFS_W-1:0]  ofs_y,
    output logic [31:0]       status,
    output logic              dma_req,
    output logic              soft_rst_p,
    output logic              fifo_clr_p,
    output logic [31:0]       rd_latch
);
    logic [1:0] dir;
    logic       idle_q, rts_q, rtr_q, dreq_q;

    dispctl_ready #(.LVL_W(LVL_W)) u_ready (
        .clk(clk), .rst_n(rst_n), .blit_state(blit_state), .cmd_busy(cmd_busy),
        .fifo_level(fifo_level), .fifo_limit(fifo_limit), .dma_dir(dir),
        .idle_q(idle_q), .rts_q(rts_q), .rtr_q(rtr_q), .dreq_q(dreq_q)
    );

    dispctl_status u_status (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_data(ctl_data),
        .irq_raise(irq_raise), .tdis_we(tdis_we), .tdis_val(tdis_val),
        .idle_q(idle_q), .rts_q(rts_q), .rtr_q(rtr_q), .dreq_q(dreq_q),
        .status(status), .dma_dir(dir), .soft_rst_p(soft_rst_p), .fifo_clr_p(fifo_clr_p)
    );

    dispctl_info #(.TW_W(TW_W), .AREA_W(AREA_W), .OFS_W(OFS_W)) u_info (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_data(ctl_data),
        .tex_win(tex_win), .area_left(area_left), .area_top(area_top),
        .area_right(area_right), .area_bottom(area_bottom),
        .ofs_x(ofs_x), .ofs_y(ofs_y), .rd_q(rd_latch)
    );

    assign dma_req = dreq_q;

    a_r6_req_mirrors_bit: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req == status[25]);
    a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_p && !(ctl_we && ctl_data[31:24] == 8'h00)) |=> !soft_rst_p);
endmodule

// File: tb/sim_dispctl_top.sv
module sim_dispctl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_data = '0;
    logic        irq_raise = 1'b0, tdis_we = 1'b0, tdis_val = 1'b0;
    logic [5:0]  fifo_level = 6'd0, fifo_limit = 6'd8;
    logic [1:0]  blit_state = 2'd0;
    logic        cmd_busy = 1'b0;
    logic [19:0] tex_win = 20'h12345;
    logic [9:0]  area_left = 10'h3A5, area_top = 10'h05A;
    logic [9:0]  area_right = 10'h1FF, area_bottom = 10'h200;
    logic [10:0] ofs_x = 11'h7FF, ofs_y = 11'h401;
    logic [31:0] status, rd_latch;
    logic        dma_req, soft_rst_p, fifo_clr_p;

    int checks = 0, errors = 0;
    logic sr_seen, fc_seen;

    always #5 clk = ~clk;

    dispctl_top u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_data(ctl_data),
        .irq_raise(irq_raise), .tdis_we(tdis_we), .tdis_val(tdis_val),
        .fifo_level(fifo_level), .fifo_limit(fifo_limit), .blit_state(blit_state),
        .cmd_busy(cmd_busy), .tex_win(tex_win), .area_left(area_left), .area_top(area_top),
        .area_right(area_right), .area_bottom(area_bottom), .ofs_x(ofs_x), .ofs_y(ofs_y),
        .status(status), .dma_req(dma_req), .soft_rst_p(soft_rst_p),
        .fifo_clr_p(fifo_clr_p), .rd_latch(rd_latch)
    );

    // {command, expected status, expected latch}
    localparam logic [95:0] VEC [19] = '{
        {32'h0300_0000, 32'h1400_2000, 32'h0000_0000},  // R4 display on
        {32'h0300_0001, 32'h1480_2000, 32'h0000_0000},  // R4 display off
        {32'h0800_00FF, 32'h14FF_6000, 32'h0000_0000},  // R7 all mode bits
        {32'h0800_0000, 32'h1480_2000, 32'h0000_0000},  // R7 clear
        {32'h0800_0041, 32'h1483_2000, 32'h0000_0000},  // R7 hres fields
        {32'h0400_0001, 32'h3683_2000, 32'h0000_0000},  // R6 dir 1
        {32'h1000_0002, 32'h3683_2000, 32'h0001_2345},  // R8 item 2
        {32'h1100_0003, 32'h3683_2000, 32'h0001_6BA5},  // R8 item 3
        {32'h1F00_0004, 32'h3683_2000, 32'h0008_01FF},  // R8 item 4
        {32'h1800_0005, 32'h3683_2000, 32'h0020_0FFF},  // R8 item 5
        {32'h1000_0000, 32'h3683_2000, 32'h0020_0FFF},  // R8 item 0 holds
        {32'h1E00_0007, 32'h3683_2000, 32'h0020_0FFF},  // R8 item 7 holds
        {32'h1C00_0001, 32'h3683_2000, 32'h0020_0FFF},  // R8 item 1 holds
        {32'h0512_3456, 32'h3683_2000, 32'h0020_0FFF},  // R10
        {32'h07FF_FFFF, 32'h3683_2000, 32'h0020_0FFF},  // R10
        {32'hFF00_0000, 32'h3683_2000, 32'h0020_0FFF},  // R10
        {32'h2000_0002, 32'h3683_2000, 32'h0020_0FFF},  // R10 not a query
        {32'h0400_0000, 32'h1483_2000, 32'h0020_0FFF},  // R6 dir off
        {32'h0000_0000, 32'h1480_2000, 32'h0020_0FFF}   // R2 soft reset
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] w);
        @(negedge clk); ctl_we = 1'b1; ctl_data = w;
        @(negedge clk); ctl_we = 1'b0; sr_seen = soft_rst_p; fc_seen = fifo_clr_p;
        @(negedge clk);
    endtask

    task automatic settle();
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status", status, 32'h1480_2000);
        chk("R1 latch", rd_latch, 32'h0);
        chk("R1 dreq", {31'b0, dma_req}, 32'h0);

        for (int i = 0; i < 19; i++) begin
            wr(VEC[i][95:64]);
            chk($sformatf("vec%0d status", i), status, VEC[i][63:32]);
            chk($sformatf("vec%0d latch", i), rd_latch, VEC[i][31:0]);
            chk($sformatf("vec%0d R6 dreq", i), {31'b0, dma_req}, {31'b0, VEC[i][57]});
        end

        // R2 soft reset pulse width and latch
        wr(32'h0000_0000);
        chk("R2 pulse high", {31'b0, sr_seen}, 32'h1);
        chk("R2 pulse one cycle", {31'b0, soft_rst_p}, 32'h0);
        chk("R2 latch kept", rd_latch, 32'h0020_0FFF);

        // R3 flush pulse, status unchanged
        wr(32'h0300_0000);
        wr(32'h0100_0000);
        chk("R3 pulse high", {31'b0, fc_seen}, 32'h1);
        chk("R3 pulse one cycle", {31'b0, fifo_clr_p}, 32'h0);
        chk("R3 status kept", status, 32'h1400_2000);

        // R4 interrupt set and acknowledge
        @(negedge clk); irq_raise = 1'b1;
        @(negedge clk); irq_raise = 1'b0;
        chk("R4 irq set", status, 32'h1500_2000);
        wr(32'h0200_0000);
        chk("R4 irq ack", status, 32'h1400_2000);

        // R9 texture-disable permission
        @(negedge clk); tdis_we = 1'b1; tdis_val = 1'b1;
        @(negedge clk); tdis_we = 1'b0;
        chk("R9 forced zero", status, 32'h1400_2000);
        wr(32'h0900_0001);
        @(negedge clk); tdis_we = 1'b1; tdis_val = 1'b1;
        @(negedge clk); tdis_we = 1'b0;
        chk("R9 allowed set", status, 32'h1400_A000);
        wr(32'h0900_0000);
        @(negedge clk); tdis_we = 1'b1; tdis_val = 1'b1;
        @(negedge clk); tdis_we = 1'b0;
        chk("R9 revoked", status, 32'h1400_2000);

        // R5 idle needs no busy cycles
        cmd_busy = 1'b1; settle();
        chk("R5 busy not idle", {31'b0, status[26]}, 32'h0);
        cmd_busy = 1'b0; settle();
        chk("R5 idle again", {31'b0, status[26]}, 32'h1);

        // R5 R6 direction x blitter x threshold matrix
        for (int d = 0; d < 4; d++) begin
            wr(32'h0400_0000 | d);
            for (int b = 0; b < 3; b++) begin
                for (int l = 7; l < 9; l++) begin
                    logic rtr, rts, exq;
                    blit_state = 2'(b); fifo_level = 6'(l);
                    settle();
                    rtr = (b != 2) && (l < 8);
                    rts = (b == 2);
                    exq = (d == 0) ? 1'b0 : (d == 3) ? rts : rtr;
                    chk($sformatf("R5 flags d%0d b%0d l%0d", d, b, l), {29'b0, status[28:26]},
                        {29'b0, rtr, rts, (b == 0)});
                    chk($sformatf("R6 dreq d%0d b%0d l%0d", d, b, l), {30'b0, dma_req, status[25]},
                        {30'b0, exq, exq});
                    chk($sformatf("R6 dir field d%0d", d), {30'b0, status[30:29]}, 32'(d));
                end
            end
        end

        // R2 soft reset clears direction and request
        blit_state = 2'd2; settle();
        wr(32'h0000_0000);
        @(negedge clk);
        chk("R2 dreq dropped", {31'b0, dma_req}, 32'h0);
        blit_state = 2'd0; fifo_level = 6'd0; settle();
        chk("R2 status reloaded", status, 32'h1480_2000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule